// File: doc/BRIEF.md
# Handshake Token Fork

This block copies every token that arrives on one valid/ready input channel onto a configurable number of valid/ready output channels. It is the point in a dynamically scheduled datapath where one result feeds several consumers. Each consumer may take the token in its own cycle. The producer is released only once all of them have it.

A build-time mode picks between two policies. In the eager policy each output is offered the token until its consumer takes it. A per-output delivered flag then withdraws that offer, so a fast consumer never sees the same token twice while a slow one is still lagging. In the lazy policy there is no per-output state: the token goes out to all consumers in one cycle, and only in a cycle where every consumer is ready.

The data width may be set to zero to build a fork for control-only tokens. In that case the data ports keep one bit and are tied low.

Top module: `tok_fork`

## Requirements
- R1: A transfer happens on a channel (the input, or output i) in exactly the cycles where that channel's valid and ready are both high.
- R2: In eager mode, output i shows valid when the input is valid and output i has not yet taken the current token. Once output i has accepted it, its valid stays low until the input accepts a new token.
- R3: In eager mode, an output that has not yet taken the current token takes it in the first cycle its own ready is high, whatever the other outputs' readies are.
- R4: In eager mode, in_ready is high exactly when every output has either already taken the current token or has its ready high in this cycle. An input transfer clears all delivered flags.
- R5: Over any run, every output receives every token exactly once and in arrival order.
- R6: In lazy mode, output i shows valid only when the input is valid and every other output is ready. All outputs transfer together, and in_ready equals the AND of all output readies.
- R7: Output i carries in_data on out_data bits [i*W +: W], where W is the data width.
- R8: With data width 0, in_data and each output slot are one bit wide, in_data is ignored, and out_data is always 0.
- R9: Synchronous active-high reset clears all delivered flags. In the first cycle after reset, an eager fork drives every out_valid equal to in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer has a token |
| in_ready | output | 1 | Fork accepts the current token this cycle |
| in_data | input | max(DATA_W,1) | Token payload |
| out_valid | output | N_OUT | Per-output token offer |
| out_ready | input | N_OUT | Per-output consumer readiness |
| out_data | output | N_OUT*max(DATA_W,1) | Payload copies, slot i at bits i*W |

## Verification
The assertions take for granted that the producer follows the handshake. Once in_valid rises, it stays high and in_data stays stable until in_ready is seen in the same cycle. Without this, the eager hold property on out_valid would not apply. The bench producer enforces this rule: it raises valid at pseudo-random times and keeps the same token until its own model predicts acceptance. The consumer readies are left free and follow a pseudo-random sequence that, over the run, covers every ready combination in every flag state.

// File: rtl/tok_fork_pkg.sv
package tok_fork_pkg;
  typedef enum logic {
    FORK_EAGER = 1'b0,
    FORK_LAZY  = 1'b1
  } fork_mode_e;

  function automatic int eff_width(input int w);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/fork_eager_ctl.sv
module fork_eager_ctl #(
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [N_OUT-1:0] out_valid,
  input  logic [N_OUT-1:0] out_ready
);
  logic [N_OUT-1:0] sent_q;
  logic [N_OUT-1:0] take;
  logic             accept;

  // One delivered flag per output; each withdraws its own offer.
  for (genvar i = 0; i < N_OUT; i++) begin : g_flag
    assign out_valid[i] = in_valid & ~sent_q[i];
    assign take[i]      = out_valid[i] & out_ready[i];

    always_ff @(posedge clk) begin
      if (rst)         sent_q[i] <= 1'b0;
      else if (accept) sent_q[i] <= 1'b0;
      else if (take[i]) sent_q[i] <= 1'b1;
    end
  end

  assign in_ready = &(sent_q | out_ready);
  assign accept   = in_valid & in_ready;
endmodule

// File: rtl/fork_lazy_ctl.sv
module fork_lazy_ctl #(
  parameter int N_OUT = 3
) (
  input  logic             in_valid,
  output logic             in_ready,
  output logic [N_OUT-1:0] out_valid,
  input  logic [N_OUT-1:0] out_ready
);
  // Output i is offered the token only when all other consumers are ready,
  // so no single consumer can take it alone.
  always_comb begin
    for (int i = 0; i < N_OUT; i++) begin
      logic [N_OUT-1:0] others;
      others       = out_ready;
      others[i]    = 1'b1;
      out_valid[i] = in_valid & (&others);
    end
  end

  assign in_ready = &out_ready;
endmodule

// File: rtl/fork_data_fan.sv
module fork_data_fan #(
  parameter int DATA_W = 8,
  parameter int N_OUT  = 3,
  localparam int DW    = tok_fork_pkg::eff_width(DATA_W)
) (
  input  logic [DW-1:0]       in_data,
  output logic [N_OUT*DW-1:0] out_data
);
  if (DATA_W == 0) begin : g_ctrl_only
    logic unused_in;
    assign unused_in = ^in_data;
    assign out_data  = '0;
  end else begin : g_copy
    for (genvar i = 0; i < N_OUT; i++) begin : g_slot
      assign out_data[i*DW +: DW] = in_data;
    end
  end
endmodule

// File: rtl/tok_fork.sv
module tok_fork
  import tok_fork_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter int         N_OUT  = 3,
  parameter fork_mode_e MODE   = FORK_EAGER,
  localparam int        DW     = eff_width(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DW-1:0]       in_data,
  output logic [N_OUT-1:0]    out_valid,
  input  logic [N_OUT-1:0]    out_ready,
  output logic [N_OUT*DW-1:0] out_data
);
  if (MODE == FORK_LAZY) begin : g_lazy
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    fork_lazy_ctl #(.N_OUT(N_OUT)) u_ctl (
      .in_valid (in_valid),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_ready(out_ready)
    );
  end else begin : g_eager
    fork_eager_ctl #(.N_OUT(N_OUT)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_ready(out_ready)
    );
  end

  fork_data_fan #(.DATA_W(DATA_W), .N_OUT(N_OUT)) u_fan (
    .in_data (in_data),
    .out_data(out_data)
  );
endmodule

// File: rtl/tok_fork_chk.sv
module tok_fork_chk #(
  parameter int N_OUT = 3,
  parameter bit LAZY  = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [N_OUT-1:0] out_valid,
  input logic [N_OUT-1:0] out_ready
);
  if (LAZY) begin : g_lazy
    a_r6_all_together: assert property (@(posedge clk) disable iff (rst)
      ((out_valid & out_ready) == '0) || ((out_valid & out_ready) == '1));
    a_r6_ready_all: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |-> (out_valid == '1));
  end else begin : g_eager
    a_r4_no_stragglers: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |-> ((out_valid & ~out_ready) == '0));
    a_r9_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_valid == {N_OUT{in_valid}}));
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      a_r2_no_second_copy: assert property (@(posedge clk) disable iff (rst)
        (out_valid[i] && out_ready[i] && !in_ready) |=> !out_valid[i]);
      a_r3_offer_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid[i] && !out_ready[i]) |=> (out_valid[i] || !in_valid));
    end
  end
endmodule

bind tok_fork tok_fork_chk #(
  .N_OUT(N_OUT),
  .LAZY (MODE == tok_fork_pkg::FORK_LAZY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready)
);

// File: tb/tok_fork_test.sv
module tok_fork_test;
  import tok_fork_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  rdy;
  logic [7:0]  din;
  logic        vin_e, vin_l;
  logic        e_ir, l_ir;
  logic [2:0]  e_ov, l_ov;
  logic [23:0] e_od, l_od;
  logic        vin_z, z_ir;
  logic [1:0]  rdy_z, z_ov, z_od;
  logic [0:0]  din_z;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  tok_fork #(.DATA_W(8), .N_OUT(3), .MODE(FORK_EAGER)) uut (
    .clk(clk), .rst(rst), .in_valid(vin_e), .in_ready(e_ir), .in_data(din),
    .out_valid(e_ov), .out_ready(rdy), .out_data(e_od));

  tok_fork #(.DATA_W(8), .N_OUT(3), .MODE(FORK_LAZY)) uut_lazy (
    .clk(clk), .rst(rst), .in_valid(vin_l), .in_ready(l_ir), .in_data(din),
    .out_valid(l_ov), .out_ready(rdy), .out_data(l_od));

  tok_fork #(.DATA_W(0), .N_OUT(2), .MODE(FORK_EAGER)) uut_ctrl (
    .clk(clk), .rst(rst), .in_valid(vin_z), .in_ready(z_ir), .in_data(din_z),
    .out_valid(z_ov), .out_ready(rdy_z), .out_data(z_od));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tok_val(input int n);
    return 8'((n * 37 + 5) & 255);
  endfunction

  // Pseudo-random sweep with a bench-side model of the requirements.
  task automatic run_fork(input bit lazy, input int cycles, input logic [15:0] seed);
    int tok = 0;
    int got [3] = '{0, 0, 0};
    bit [2:0] ms = '0;
    bit v = 1'b0;
    logic [15:0] lf = seed;
    for (int c = 0; c < cycles; c++) begin
      logic [2:0] ev, ov, fire;
      logic eir, ir;
      logic [23:0] od;
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (!v && lf[7]) v = 1'b1;
      rdy   = lf[2:0];
      din   = tok_val(tok);
      vin_e = lazy ? 1'b0 : v;
      vin_l = lazy ? v : 1'b0;
      #1;
      if (lazy) begin
        for (int i = 0; i < 3; i++) begin
          logic [2:0] oth;
          oth   = rdy;
          oth[i] = 1'b1;
          ev[i] = v & (&oth);
        end
        eir = &rdy;
        ov = l_ov; ir = l_ir; od = l_od;
        chk(ov == ev, "R6 lazy out_valid", int'(ov), int'(ev));
        chk(ir == eir, "R6 lazy in_ready", int'(ir), int'(eir));
      end else begin
        ev  = {3{v}} & ~ms;
        eir = &(ms | rdy);
        ov = e_ov; ir = e_ir; od = e_od;
        chk(ov == ev, "R2/R3 eager out_valid", int'(ov), int'(ev));
        chk(ir == eir, "R4 eager in_ready", int'(ir), int'(eir));
      end
      fire = ov & rdy;
      for (int i = 0; i < 3; i++) begin
        if (fire[i]) begin
          chk(od[i*8 +: 8] == tok_val(got[i]), "R5/R7 token order and slot data",
              int'(od[i*8 +: 8]), int'(tok_val(got[i])));
          got[i]++;
        end
      end
      if (v && eir) begin
        ms = '0; tok++; v = 1'b0;
      end else begin
        ms = ms | fire;
      end
    end
    @(negedge clk);
    vin_e = 1'b0; vin_l = 1'b0;
    for (int i = 0; i < 3; i++)
      chk(got[i] == tok + int'(ms[i]), "R5 exactly-once count", got[i], tok + int'(ms[i]));
    chk(tok > 50, "R1 input transfers occurred", tok, 51);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rdy = '0; din = '0; vin_e = 0; vin_l = 0;
    vin_z = 0; rdy_z = '0; din_z = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state, eager offers the token to every output
    vin_e = 1'b1; rdy = 3'b000; din = 8'hA5;
    #1;
    chk(e_ov == 3'b111, "R9 valid after reset", int'(e_ov), 7);
    chk(e_ir == 1'b0, "R4 no accept with none ready", int'(e_ir), 0);
    chk(e_od == {3{8'hA5}}, "R7 slot copies", int'(e_od[7:0]), 'hA5);
    // R3: only output 0 ready, it takes the token alone
    @(negedge clk); rdy = 3'b001; #1;
    chk(e_ov == 3'b111 && e_ir == 1'b0, "R3 lone consumer offered", int'(e_ov), 7);
    @(negedge clk); rdy = 3'b111; #1;
    chk(e_ov == 3'b110, "R2 delivered output withdrawn", int'(e_ov), 6);
    chk(e_ir == 1'b1, "R4 remaining all ready", int'(e_ir), 1);
    rdy = 3'b000;
    // R9: mid-token reset clears the delivered flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk(e_ov == 3'b111, "R9 flags cleared by reset", int'(e_ov), 7);
    vin_e = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;

    run_fork(1'b0, 3000, 16'hACE1);
    run_fork(1'b1, 3000, 16'h1D2B);

    // R8: control-only fork
    @(negedge clk); vin_z = 1'b1; rdy_z = 2'b10; #1;
    chk(z_ov == 2'b11, "R8 control-only valid", int'(z_ov), 3);
    chk(z_od == 2'b00, "R8 data tied low", int'(z_od), 0);
    @(negedge clk); rdy_z = 2'b01; #1;
    chk(z_ov == 2'b01, "R2 control-only withdrawn", int'(z_ov), 1);
    chk(z_ir == 1'b1, "R4 control-only accept", int'(z_ir), 1);
    @(negedge clk); vin_z = 1'b0; rdy_z = 2'b00; #1;
    chk(z_ov == 2'b00 && z_od == 2'b00, "R1 control-only idle", int'(z_ov), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule